// File: doc/BRIEF.md
# I2C Control-Port Target

This block is a byte-wide I2C-compatible target that sits between an external bus host and an on-chip core. The host writes control bytes into an input holding register and reads bytes back from an output holding register. The host drives SCL. SDA is handled as an open-drain pair: the block reads the wired line and asserts a pull-down enable. The core sees a one-cycle write strobe with the received byte. It fills the output holding register through a load port. An active-low request line tells the host that read data is waiting.

A chip-select pin is latched during reset and picks the port mode. Only the I2C mode is built here. With the other mode latched, the block stays silent on the bus. The target address is a 7-bit value that the core programs, together with an address-check enable. Until that enable is set, the block answers every address on the bus. The host must still send a full address byte with its R/W bit. Both SCL and SDA pass through synchronisers into the system clock domain before start, stop and edge detection.

Top module: `i2c_ctl_slave`

## Requirements
- R1: The mode is captured from `cs_pin` on every clock while `rst` is high; high selects I2C. With low captured, the block never asserts `sda_oe` and never pulses `inreg_wr`.
- R2: SDA is sampled on rising SCL. After a start, the first byte carries the 7-bit address MSB first, then the R/W bit in bit 0 (0 = write, 1 = read).
- R3: The address-check enable resets to 0. While it is 0, any address is acknowledged by pulling SDA low during the ninth clock.
- R4: With the enable at 1, only an address equal to the programmed one is acknowledged. Any other address gets no ACK, and the bytes that follow are ignored (no `inreg_wr`) until the next start.
- R5: Write data is shifted in MSB first. On the falling SCL of the eighth bit, `inreg_data` takes the byte, `inreg_wr` pulses for one clock, and an ACK is driven during the ninth clock.
- R6: `req_n` is high after reset and goes low when `outreg_ld` loads the output holding register.
- R7: A read sends the output holding register MSB first, with SDA pulled low for each 0 bit. `req_n` returns high after the falling SCL that ends the eighth bit.
- R8: SDA is released during the host's acknowledge clock. After an ACK the held byte is sent again. After a NACK the block drives nothing more.
- R9: A stop condition, or a repeated start, abandons any byte in progress from any state. A stop leads to idle and a start leads to a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_pin | input | 1 | Mode select, captured during reset (1 = I2C) |
| scl_in | input | 1 | Bus clock from the host |
| sda_in | input | 1 | Wired SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| req_n | output | 1 | Active-low: output holding register has unread data |
| inreg_wr | output | 1 | One-cycle strobe: new byte in `inreg_data` |
| inreg_data | output | 8 | Input holding register |
| outreg_ld | input | 1 | Load strobe for the output holding register |
| outreg_din | input | 8 | Byte to load into the output holding register |
| cfg_we | input | 1 | Write strobe for address and check enable |
| cfg_addr | input | 7 | Own bus address |
| cfg_aen | input | 1 | Address-check enable |

## Verification
The hardest cases are a stop or a repeated start that arrives partway through a data byte. The shifter then holds a partial byte that must never reach the core. The bench builds these by bit-level bus tasks that can break off a byte after any number of bits. It then checks that no write strobe appeared and that the next full transfer lands cleanly. Random transfers mix the check-enable state with matching and non-matching addresses, so both branches of the address filter are exercised against an expected ACK computed in the bench.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } bus_st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic chk,
                                      input logic [ADDR_W-1:0] mine,
                                      input logic [ADDR_W-1:0] got);
        return !chk || (mine == got);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] now;
    logic [NLINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw[i]};
            end
        end
        assign now[i] = pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
        end else begin
            prev <= now;
        end
    end

    always_comb begin
        ev.scl      = now[1];
        ev.sda      = now[0];
        ev.scl_rise = now[1] & ~prev[1];
        ev.scl_fall = ~now[1] & prev[1];
        ev.start    = now[1] & prev[1] & prev[0] & ~now[0];
        ev.stop     = now[1] & prev[1] & ~prev[0] & now[0];
    end

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  line_ev_t          ev,
    input  logic              chk_en,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              rx_we,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_done
);
    bus_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw;
    logic              mst_ack;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            rw      <= 1'b0;
            mst_ack <= 1'b0;
            sda_oe  <= 1'b0;
            rx_we   <= 1'b0;
            tx_done <= 1'b0;
            if (rst) rx_byte <= '0;
        end else begin
            rx_we   <= 1'b0;
            tx_done <= 1'b0;
            if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (addr_hit(chk_en, my_addr, sh[BYTE_W-1:1])) begin
                                st     <= ST_ADDR_ACK;
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                st     <= ST_RD_DATA;
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                            end else begin
                                st     <= ST_WR_DATA;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_DATA: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            rx_byte <= sh;
                            rx_we   <= 1'b1;
                            sda_oe  <= 1'b1;
                            st      <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= ST_WR_DATA;
                        end
                    end
                    ST_RD_DATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                sda_oe  <= 1'b0;
                                tx_done <= 1'b1;
                                st      <= ST_RD_ACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mst_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mst_ack) begin
                                st     <= ST_RD_DATA;
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                cnt    <= '0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> st == ST_IDLE); // R9
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (en && ev.start && !ev.stop) |=> st == ST_ADDR); // R9
    AST_RX_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADDR || st == ST_WR_DATA) |-> !sda_oe); // R5
    AST_HOST_ACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_ACK) |-> !sda_oe); // R8
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_we |=> !rx_we); // R5

endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
    import i2c_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_pin,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              req_n,
    output logic              inreg_wr,
    output logic [BYTE_W-1:0] inreg_data,
    input  logic              outreg_ld,
    input  logic [BYTE_W-1:0] outreg_din,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_aen
);
    line_ev_t          ev;
    logic              mode_i2c;
    logic              aen_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] out_q;
    logic              out_valid;
    logic              tx_done;

    always_ff @(posedge clk) begin
        if (rst) mode_i2c <= cs_pin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aen_q  <= 1'b0;
            addr_q <= '0;
        end else if (cfg_we) begin
            aen_q  <= cfg_aen;
            addr_q <= cfg_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            out_valid <= 1'b0;
        end else if (outreg_ld) begin
            out_q     <= outreg_din;
            out_valid <= 1'b1;
        end else if (tx_done) begin
            out_valid <= 1'b0;
        end
    end

    assign req_n = ~out_valid;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_byte_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (mode_i2c),
        .ev      (ev),
        .chk_en  (aen_q),
        .my_addr (addr_q),
        .tx_byte (out_q),
        .sda_oe  (sda_oe),
        .rx_we   (inreg_wr),
        .rx_byte (inreg_data),
        .tx_done (tx_done)
    );

    AST_MODE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !mode_i2c |-> (!sda_oe && !inreg_wr)); // R1
    AST_REQ_FALL_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n) |-> $past(outreg_ld)); // R6
    AST_REQ_RISE_ON_SEND: assert property (@(posedge clk) disable iff (rst)
        $rose(req_n) |-> !$past(outreg_ld)); // R7

endmodule

// File: tb/tb_i2c_ctl_slave.sv
module tb_i2c_ctl_slave;
    localparam int H = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic       cs_pin = 1;
    logic       scl_m = 1;
    logic       sda_m = 1;
    logic       sda_oe, req_n, inreg_wr;
    logic [7:0] inreg_data;
    logic       outreg_ld = 0;
    logic [7:0] outreg_din = 0;
    logic       cfg_we = 0;
    logic [6:0] cfg_addr = 0;
    logic       cfg_aen = 0;
    wire        sda_line = sda_m & ~sda_oe;

    int total = 0, bad = 0, wr_cnt = 0, oe_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_ctl_slave dut (
        .clk(clk), .rst(rst), .cs_pin(cs_pin), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .req_n(req_n), .inreg_wr(inreg_wr), .inreg_data(inreg_data),
        .outreg_ld(outreg_ld), .outreg_din(outreg_din),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_aen(cfg_aen)
    );

    always @(posedge clk) begin
        if (inreg_wr) wr_cnt <= wr_cnt + 1;
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    function automatic bit exp_ack(bit aen, logic [6:0] mine, logic [6:0] got);
        return !aen || (mine == got);
    endfunction

    function automatic logic [7:0] frame(logic [6:0] a, bit rd);
        return {a, rd};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp();
    endtask

    task automatic put_bit(input bit b, output bit oe_seen);
        sda_m = b; hp(); scl_m = 1; hp(); oe_seen = sda_oe; scl_m = 0; hp();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1; hp(); scl_m = 1; hp(); b = sda_line; scl_m = 0; hp();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit o, b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], o);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack, output bit oe_in_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack, oe_in_ack);
    endtask

    task automatic set_cfg(input bit aen, input logic [6:0] a);
        cfg_aen = aen; cfg_addr = a; cfg_we = 1;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic load_out(input logic [7:0] v);
        outreg_din = v; outreg_ld = 1;
        @(negedge clk); outreg_ld = 0;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit cs);
        cs_pin = cs; rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack, o, b;
        logic [7:0] v;
        int w0;
        do_reset(1);
        check("R6 req_n after reset", req_n, 1);
        check("R5 inreg_data after reset", inreg_data, 0);
        check("R1 sda released after reset", sda_oe, 0);

        // R3: promiscuous by default
        w0 = wr_cnt;
        bus_start(); send_byte(frame(7'h5A, 0), ack);
        check("R3 any address acked", ack, 1);
        send_byte(8'hC3, ack);
        check("R5 data acked", ack, 1);
        check("R5 inreg_data", inreg_data, 8'hC3);
        check("R5 one strobe", wr_cnt - w0, 1);
        bus_stop();

        // random mix of check enable and address
        for (int n = 0; n < 24; n++) begin
            bit aen;
            logic [6:0] a;
            logic [7:0] d;
            bit e;
            aen = 1'($urandom % 2);
            a = ($urandom % 2) ? 7'h21 : 7'($urandom);
            d = 8'($urandom);
            set_cfg(aen, 7'h21);
            e = exp_ack(aen, 7'h21, a);
            w0 = wr_cnt;
            bus_start(); send_byte(frame(a, 0), ack);
            check("R4 R2 address filter ack", ack, e);
            send_byte(d, ack);
            check("R4 data ack follows address", ack, e);
            check("R4 R5 strobe count", wr_cnt - w0, e ? 1 : 0);
            if (e) check("R5 random byte", inreg_data, d);
            bus_stop();
        end

        // R2: address bit order, 0x21 vs its reversal 0x42
        set_cfg(1, 7'h21);
        bus_start(); send_byte(frame(7'h42, 0), ack);
        check("R2 reversed address not acked", ack, 0);
        bus_stop();

        // R7/R8 read with NACK
        load_out(8'hA5);
        check("R6 req_n low after load", req_n, 0);
        bus_start(); send_byte(frame(7'h21, 1), ack);
        check("R2 read address acked", ack, 1);
        recv_byte(v, 0, o);
        check("R7 read byte MSB first", v, 8'hA5);
        check("R8 sda released in host ack", o, 0);
        check("R7 req_n high after send", req_n, 1);
        get_bit(b);
        check("R8 silent after NACK", b, 1);
        bus_stop();

        // R8 read with ACK continues
        load_out(8'h3C);
        bus_start(); send_byte(frame(7'h21, 1), ack);
        recv_byte(v, 1, o);
        check("R7 first byte", v, 8'h3C);
        check("R8 released during host ACK", o, 0);
        recv_byte(v, 0, o);
        check("R8 second byte after ACK", v, 8'h3C);
        bus_stop();

        // R9 stop inside a data byte
        w0 = wr_cnt;
        bus_start(); send_byte(frame(7'h21, 0), ack);
        put_bit(1, o); put_bit(0, o); put_bit(1, o);
        bus_stop();
        check("R9 no strobe on aborted byte", wr_cnt - w0, 0);
        bus_start(); send_byte(frame(7'h21, 0), ack); send_byte(8'h77, ack);
        bus_stop();
        check("R9 next transfer after stop", inreg_data, 8'h77);

        // R9 repeated start inside a data byte
        w0 = wr_cnt;
        bus_start(); send_byte(frame(7'h21, 0), ack);
        put_bit(0, o); put_bit(1, o);
        bus_start(); send_byte(frame(7'h21, 0), ack);
        check("R9 address after repeated start", ack, 1);
        send_byte(8'h19, ack);
        bus_stop();
        check("R9 byte after repeated start", inreg_data, 8'h19);
        check("R9 single strobe", wr_cnt - w0, 1);

        // R1 other mode: silent
        do_reset(0);
        w0 = wr_cnt; oe_cnt = 0;
        bus_start(); send_byte(frame(7'h10, 0), ack);
        check("R1 no ack in other mode", ack, 0);
        send_byte(8'hEE, ack);
        bus_stop();
        check("R1 no strobe in other mode", wr_cnt - w0, 0);
        check("R1 sda never driven", oe_cnt, 0);

        // R3 enable cleared by reset
        set_cfg(1, 7'h21);
        do_reset(1);
        bus_start(); send_byte(frame(7'h44, 0), ack);
        check("R3 check enable reset to 0", ack, 1);
        bus_stop();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule